// File: doc/BRIEF.md
# Read-After-Write Stall Unit

This unit guards the operand-read stage of a six-stage in-order pipeline (fetch, decode, read, execute, memory, write-back). It receives the two source specifiers of the instruction currently in the read stage. It keeps its own record of the destination tag of every older instruction in execute, memory and write-back. When a source that the instruction actually uses names a register that a valid, writing instruction in execute or memory will produce, the unit raises a stall. The stall tells fetch, decode and read to hold their contents, and it pushes an empty slot into execute in place of the waiting instruction.

The register file writes through: a value committed in write-back can be read in the same cycle. A producer in write-back therefore never blocks. Register zero always reads as zero, so it never creates a dependence. The pipeline has a single register write stage and a single data-memory stage, and reads happen before writes, so output, anti and memory dependences cannot be violated. The unit checks only true dependences. The write-back tag leaves the unit so the register file can use it as its write command.

Top module: `raw_stall_unit`

## Requirements
- R1: After reset the execute, memory and write-back tags are empty, so `wb_valid_o` is 0 and `stall_o` is 0 for any read-stage instruction.
- R2: `stall_o` is 1 when a used, nonzero source equals the destination of a valid, writing instruction in execute.
- R3: `stall_o` is 1 when a used, nonzero source equals the destination of a valid, writing instruction in memory.
- R4: A matching producer that has reached write-back causes no stall.
- R5: A source index of 0 never causes a stall, even if an older instruction names register 0 as its destination.
- R6: A source whose used flag is 0 is ignored, whatever its index.
- R7: In every stalled cycle, the entry pushed into execute has valid = 0 and write enable = 0. It reaches `wb_valid_o` as 0 two cycles later.
- R8: A read-stage instruction with `rd_valid_i` = 1 that is not stalled enters execute at the next edge. Its valid, write enable and destination appear on the write-back outputs three edges after it is accepted.
- R9: The stall releases in the cycle the producer reaches write-back. A dependent instruction directly behind its producer stalls for exactly 2 cycles, and one that is two places behind stalls for 1 cycle.
- R10: An older instruction with write enable 0 never causes a stall.
- R11: When `rd_valid_i` is 0, `stall_o` is 0 and an empty entry is pushed into execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_valid_i | input | 1 | The read stage holds an instruction |
| src_a_used_i | input | 1 | First source is read by the instruction |
| src_a_idx_i | input | $clog2(REG_COUNT) | First source register index |
| src_b_used_i | input | 1 | Second source is read by the instruction |
| src_b_idx_i | input | $clog2(REG_COUNT) | Second source register index |
| rd_wen_i | input | 1 | Read-stage instruction writes a register |
| rd_dst_i | input | $clog2(REG_COUNT) | Read-stage instruction destination |
| stall_o | output | 1 | Hold fetch/decode/read and bubble execute |
| wb_valid_o | output | 1 | Write-back stage holds a real instruction |
| wb_wen_o | output | 1 | Write-back stage writes the register file |
| wb_dst_o | output | $clog2(REG_COUNT) | Write-back destination |

## Verification
The bench checks stall length against producer distance: zero, one and two cycles. A unit that compared against write-back would add a third stall cycle, and one that ignored memory would let a dependent slip through early. It sends register-zero destinations and sources, unused source fields and non-writing producers through. These expose a comparator that forgets the zero test, the used flag or the write enable. It also follows a stalled pair to write-back, to show that the empty slots arrive with valid and write enable cleared and that the held instruction arrives after them.

// File: rtl/rsu_pkg.sv
`timescale 1ns/1ps
package rsu_pkg;
    // Stages after the read stage, in order of age (youngest first).
    typedef enum int unsigned {
        STG_EX  = 0,
        STG_MEM = 1,
        STG_WB  = 2
    } tail_stage_e;

    localparam int unsigned TAIL_DEPTH = 3;
    localparam int unsigned SRC_COUNT  = 2;
endpackage

// File: rtl/rsu_src_match.sv
`timescale 1ns/1ps
module rsu_src_match #(
    parameter int unsigned AW   = 5,
    parameter int unsigned NCHK = 2
) (
    input  logic               src_used_i,
    input  logic [AW-1:0]      src_idx_i,
    input  logic [NCHK-1:0]    wr_valid_i,
    input  logic [NCHK-1:0]    wr_wen_i,
    input  logic [NCHK*AW-1:0] wr_dst_i,
    output logic               hit_o
);
    logic [NCHK-1:0] stage_hit;
    logic            src_live;

    // Register zero is constant, so it can never carry a dependence.
    assign src_live = src_used_i && (src_idx_i != '0);

    for (genvar k = 0; k < NCHK; k++) begin : g_cmp
        assign stage_hit[k] = wr_valid_i[k] && wr_wen_i[k]
                              && (wr_dst_i[k*AW +: AW] == src_idx_i);
    end

    assign hit_o = src_live && (|stage_hit);
endmodule

// File: rtl/rsu_tag_pipe.sv
`timescale 1ns/1ps
module rsu_tag_pipe #(
    parameter int unsigned AW    = 5,
    parameter int unsigned DEPTH = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                in_valid_i,
    input  logic                in_wen_i,
    input  logic [AW-1:0]       in_dst_i,
    output logic [DEPTH-1:0]    tag_valid_o,
    output logic [DEPTH-1:0]    tag_wen_o,
    output logic [DEPTH*AW-1:0] tag_dst_o
);
    typedef struct packed {
        logic          valid;
        logic          wen;
        logic [AW-1:0] dst;
    } tag_t;

    typedef struct packed {
        tag_t [DEPTH-1:0] stg;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.stg[0].valid = in_valid_i;
        pipe_d.stg[0].wen   = in_wen_i && in_valid_i;
        pipe_d.stg[0].dst   = in_dst_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d.stg[i] = pipe_q.stg[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign tag_valid_o[i]          = pipe_q.stg[i].valid;
        assign tag_wen_o[i]            = pipe_q.stg[i].wen;
        assign tag_dst_o[i*AW +: AW]   = pipe_q.stg[i].dst;

        if (i > 0) begin : g_chk
            // R8: every tag moves one stage per cycle, unchanged.
            assert_tag_shift_R8: assert property (@(posedge clk_i) disable iff (rst_i)
                1'b1 |=> (pipe_q.stg[i] == $past(pipe_q.stg[i-1])));
        end
    end
endmodule

// File: rtl/raw_stall_unit.sv
`timescale 1ns/1ps
module raw_stall_unit
    import rsu_pkg::*;
#(
    parameter int unsigned REG_COUNT = 32,
    parameter int unsigned PIPE_TAIL = TAIL_DEPTH
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          rd_valid_i,
    input  logic                          src_a_used_i,
    input  logic [$clog2(REG_COUNT)-1:0]  src_a_idx_i,
    input  logic                          src_b_used_i,
    input  logic [$clog2(REG_COUNT)-1:0]  src_b_idx_i,
    input  logic                          rd_wen_i,
    input  logic [$clog2(REG_COUNT)-1:0]  rd_dst_i,
    output logic                          stall_o,
    output logic                          wb_valid_o,
    output logic                          wb_wen_o,
    output logic [$clog2(REG_COUNT)-1:0]  wb_dst_o
);
    localparam int unsigned AW   = $clog2(REG_COUNT);
    // Write-back writes through, so only the stages before it are checked.
    localparam int unsigned NCHK = PIPE_TAIL - 1;
    localparam int unsigned RW   = $clog2(PIPE_TAIL + 1);
    localparam logic [RW-1:0] NCHK_W = RW'(NCHK);
    localparam int unsigned WB_IX = PIPE_TAIL - 1;

    logic [PIPE_TAIL-1:0]    tag_valid;
    logic [PIPE_TAIL-1:0]    tag_wen;
    logic [PIPE_TAIL*AW-1:0] tag_dst;

    logic [SRC_COUNT-1:0]    src_used;
    logic [SRC_COUNT*AW-1:0] src_idx;
    logic [SRC_COUNT-1:0]    src_hit;

    logic hazard;
    logic issue;

    assign src_used = {src_b_used_i, src_a_used_i};
    assign src_idx  = {src_b_idx_i, src_a_idx_i};

    for (genvar s = 0; s < SRC_COUNT; s++) begin : g_src
        rsu_src_match #(
            .AW   (AW),
            .NCHK (NCHK)
        ) u_match (
            .src_used_i (src_used[s]),
            .src_idx_i  (src_idx[s*AW +: AW]),
            .wr_valid_i (tag_valid[NCHK-1:0]),
            .wr_wen_i   (tag_wen[NCHK-1:0]),
            .wr_dst_i   (tag_dst[NCHK*AW-1:0]),
            .hit_o      (src_hit[s])
        );
    end

    assign hazard  = rd_valid_i && (|src_hit);
    assign stall_o = hazard;
    // A stalled or empty read stage sends an empty slot into execute.
    assign issue   = rd_valid_i && !hazard;

    rsu_tag_pipe #(
        .AW    (AW),
        .DEPTH (PIPE_TAIL)
    ) u_tags (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .in_valid_i  (issue),
        .in_wen_i    (rd_wen_i),
        .in_dst_i    (rd_dst_i),
        .tag_valid_o (tag_valid),
        .tag_wen_o   (tag_wen),
        .tag_dst_o   (tag_dst)
    );

    assign wb_valid_o = tag_valid[WB_IX];
    assign wb_wen_o   = tag_wen[WB_IX];
    assign wb_dst_o   = tag_dst[WB_IX*AW +: AW];

    // Length of the current run of stall cycles, used by the R9 check.
    typedef struct packed {
        logic [RW-1:0] run;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (!hazard) begin
            ctl_d.run = '0;
        end else if (ctl_q.run != NCHK_W) begin
            ctl_d.run = ctl_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assert_zero_src_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_valid_i && (!src_a_used_i || src_a_idx_i == '0)
                    && (!src_b_used_i || src_b_idx_i == '0)) |-> !stall_o);

    assert_empty_read_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_valid_i |-> !stall_o);

    assert_bubble_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |=> (!tag_valid[STG_EX] && !tag_wen[STG_EX]));

    assert_stall_bound_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |-> (ctl_q.run < NCHK_W));

    assert_issue_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_valid_i && !stall_o) |=>
            (tag_valid[STG_EX] && tag_dst[STG_EX*AW +: AW] == $past(rd_dst_i)));
endmodule

// File: tb/sim_raw_stall_unit.sv
`timescale 1ns/1ps
module sim_raw_stall_unit;
    localparam int unsigned AW = 5;
    localparam int unsigned NROWS = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_valid = 1'b0;
    logic          ua = 1'b0;
    logic [AW-1:0] sa = '0;
    logic          ub = 1'b0;
    logic [AW-1:0] sb = '0;
    logic          we = 1'b0;
    logic [AW-1:0] dst = '0;
    logic          stall;
    logic          wb_valid;
    logic          wb_wen;
    logic [AW-1:0] wb_dst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    raw_stall_unit u0 (
        .clk_i        (clk),
        .rst_i        (rst),
        .rd_valid_i   (rd_valid),
        .src_a_used_i (ua),
        .src_a_idx_i  (sa),
        .src_b_used_i (ub),
        .src_b_idx_i  (sb),
        .rd_wen_i     (we),
        .rd_dst_i     (dst),
        .stall_o      (stall),
        .wb_valid_o   (wb_valid),
        .wb_wen_o     (wb_wen),
        .wb_dst_o     (wb_dst)
    );

    // Row: {valid, useA, srcA, useB, srcB, wen, dst, expected stall}
    localparam logic [19:0] TBL [NROWS] = '{
        {1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b1, 5'd5,  1'b0}, // producer of r5
        {1'b1, 1'b1, 5'd5,  1'b0, 5'd0,  1'b1, 5'd6,  1'b1}, // R2 r5 in execute
        {1'b1, 1'b1, 5'd5,  1'b0, 5'd0,  1'b1, 5'd6,  1'b1}, // R3 r5 in memory
        {1'b1, 1'b1, 5'd5,  1'b0, 5'd0,  1'b1, 5'd6,  1'b0}, // R4 R9 released
        {1'b1, 1'b1, 5'd7,  1'b1, 5'd8,  1'b1, 5'd7,  1'b0}, // independent
        {1'b1, 1'b0, 5'd0,  1'b1, 5'd6,  1'b0, 5'd9,  1'b1}, // R3 R9 two behind
        {1'b1, 1'b0, 5'd0,  1'b1, 5'd6,  1'b0, 5'd9,  1'b0}, // R9 released
        {1'b1, 1'b1, 5'd9,  1'b0, 5'd0,  1'b1, 5'd0,  1'b0}, // R10 non-writer
        {1'b1, 1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 5'd10, 1'b0}, // R5 r0 dest ahead
        {1'b1, 1'b0, 5'd10, 1'b0, 5'd10, 1'b1, 5'd11, 1'b0}, // R6 unused srcs
        {1'b0, 1'b1, 5'd11, 1'b0, 5'd0,  1'b1, 5'd11, 1'b0}, // R11 empty read
        {1'b1, 1'b0, 5'd0,  1'b1, 5'd11, 1'b1, 5'd12, 1'b1}, // R3 after empty
        {1'b1, 1'b0, 5'd0,  1'b1, 5'd11, 1'b1, 5'd12, 1'b0}, // R9 released
        {1'b1, 1'b1, 5'd12, 1'b1, 5'd12, 1'b0, 5'd0,  1'b1}, // R2 both srcs
        {1'b1, 1'b1, 5'd12, 1'b1, 5'd12, 1'b0, 5'd0,  1'b1}, // R3
        {1'b1, 1'b1, 5'd12, 1'b1, 5'd12, 1'b0, 5'd0,  1'b0}  // R9 released
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic u1, input logic [AW-1:0] s1,
                         input logic u2, input logic [AW-1:0] s2,
                         input logic w, input logic [AW-1:0] d);
        rd_valid = v; ua = u1; sa = s1; ub = u2; sb = s2; we = w; dst = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: empty after reset
        #2;
        check("R1 stall after reset", int'(stall), 0);
        check("R1 wb_valid after reset", int'(wb_valid), 0);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            drive(TBL[i][19], TBL[i][18], TBL[i][17:13], TBL[i][12],
                  TBL[i][11:7], TBL[i][6], TBL[i][5:1]);
            #2;
            check($sformatf("R2/R3/R4/R5/R6/R9/R10/R11 row %0d stall", i),
                  int'(stall), int'(TBL[i][0]));
        end

        // R8: latency to write-back
        do_reset();
        drive(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 5'd3);
        @(negedge clk);
        drive(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        @(negedge clk);
        #2;
        check("R8 wb_valid after two edges", int'(wb_valid), 0);
        @(negedge clk);
        #2;
        check("R8 wb_valid after three edges", int'(wb_valid), 1);
        check("R8 wb_dst", int'(wb_dst), 3);
        check("R8 wb_wen", int'(wb_wen), 1);

        // R7: bubbles behind a stalled pair
        do_reset();
        drive(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 5'd4);
        @(negedge clk);
        drive(1'b1, 1'b1, 5'd4, 1'b0, '0, 1'b1, 5'd5);
        #2;
        check("R2 back-to-back stall", int'(stall), 1);
        @(negedge clk);
        #2;
        check("R3 second stall cycle", int'(stall), 1);
        @(negedge clk);
        #2;
        check("R4 release with producer in wb", int'(stall), 0);
        check("R4 producer at wb", int'(wb_dst), 4);
        @(negedge clk);
        drive(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        #2;
        check("R7 first bubble valid", int'(wb_valid), 0);
        check("R7 first bubble wen", int'(wb_wen), 0);
        @(negedge clk);
        #2;
        check("R7 second bubble valid", int'(wb_valid), 0);
        @(negedge clk);
        #2;
        check("R8 held instruction valid at wb", int'(wb_valid), 1);
        check("R8 held instruction dst at wb", int'(wb_dst), 5);

        // R1: reset clears a loaded pipeline
        @(negedge clk);
        drive(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 5'd9);
        @(negedge clk);
        rst = 1'b1;
        drive(1'b1, 1'b1, 5'd9, 1'b0, '0, 1'b1, 5'd1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 no stall after mid-flight reset", int'(stall), 0);
        check("R1 wb empty after mid-flight reset", int'(wb_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule